// File: doc/BRIEF.md
# I2C FIFO Interrupt Status Unit

This block keeps the raw interrupt conditions of an I2C controller that sit around its receive and transmit FIFOs and around bus events. It watches the FIFO fill levels, the software read and write strobes, byte arrivals from the bus, the controller enable, an indication that both protocol state machines are idle, and single-cycle event pulses from the bus logic. From these it keeps a ten-bit raw status vector, a record of transmit-abort causes, a hold that keeps the transmit FIFO flushed after an abort, and one interrupt line that is the masked OR of the status.

Every status bit is registered. An input presented before a rising clock edge shows on the outputs after that edge. The level flags follow the FIFO levels and cannot be cleared. The error flags and event flags latch, and are cleared by a per-bit clear input or by a single clear-all input. When a flag's set condition and its clear come in the same cycle, the set wins, so no new event is lost.

Top module: `i2c_irq_status`

## Requirements
- R1: After reset, raw_status, abort_src and irq are all zero.
- R2: With ctrl_en high, bit 2 (receive threshold) is 1 one cycle after rx_level >= rx_thresh and 0 one cycle after rx_level < rx_thresh.
- R3: With ctrl_en high and no abort held, bit 4 (transmit threshold) is 1 one cycle after tx_level <= tx_thresh and 0 one cycle after tx_level > tx_thresh.
- R4: With ctrl_en high, three error bits latch as follows. Bit 0 latches when rx_pop comes while rx_level is 0. Bit 1 latches when rx_push comes while rx_level equals DEPTH. Bit 3 latches when tx_push comes while tx_level equals DEPTH and no abort is held.
- R5: With ctrl_en low, bit 2 reads 0 and bit 4 reads the inverse of fsm_idle, one cycle later.
- R6: With ctrl_en low, bits 0, 1 and 3 keep their value while fsm_idle is low and clear one cycle after fsm_idle is high.
- R7: An ev_abort pulse sets bit 5 and ORs abort_cause into abort_src. While bit 5 is set, tx_flush is high and bit 4 reads 1 when ctrl_en is high, whatever tx_level is. Bit 5 holds until cleared, and that clear also zeroes abort_src. tx_flush is also high whenever ctrl_en is low.
- R8: Pulses on ev_activity, ev_stop and ev_start set bits 6, 7 and 8. ev_start covers both START and repeated START. These bits stay set until cleared. ev_gcall sets bit 9 only while ctrl_en is high, and bit 9 clears when ctrl_en goes low.
- R9: flag_clr[i] clears only latched bit i, and clr_all clears every latched bit (0, 1, 3, 5 to 9) in one cycle. Clears have no effect on bits 2 and 4. A set in the same cycle wins over a clear.
- R10: irq equals the OR of raw_status AND irq_mask, in the same cycle as raw_status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_en | input | 1 | Controller enable |
| fsm_idle | input | 1 | Both protocol state machines idle |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_thresh | input | LVL_W | Receive threshold |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| tx_thresh | input | LVL_W | Transmit threshold |
| rx_pop | input | 1 | Software read of the receive FIFO |
| rx_push | input | 1 | Byte arrives from the bus |
| tx_push | input | 1 | Software write to the transmit FIFO |
| ev_abort | input | 1 | Transmit abort pulse |
| abort_cause | input | CAUSE_W | Cause bits that come with ev_abort |
| ev_activity | input | 1 | Bus activity pulse |
| ev_stop | input | 1 | STOP detected pulse |
| ev_start | input | 1 | START or repeated START pulse |
| ev_gcall | input | 1 | Acknowledged general call pulse |
| flag_clr | input | 10 | Per-bit clear of latched flags |
| clr_all | input | 1 | Clear every latched flag |
| irq_mask | input | 10 | Per-bit interrupt enable |
| raw_status | output | 10 | Raw status vector |
| irq | output | 1 | Combined masked interrupt |
| tx_flush | output | 1 | Hold the transmit FIFO flushed |
| abort_src | output | CAUSE_W | Accumulated abort causes |

## Verification
The hardest state to reach is a disabled controller that still carries latched error flags while a state machine stays busy. The error flags can only be set while the controller is enabled. The stimulus therefore drives the FIFO to both boundaries with the controller enabled to latch all three error bits, drops the enable with fsm_idle low to check that the bits hold, and then raises fsm_idle to check that they clear. An abort held against a full transmit level is set up in the same directed way. A long seeded random phase then mixes enables, idles, boundary levels, events and clears against a bench model built from the requirements.

// File: rtl/isu_pkg.sv
package isu_pkg;
    localparam int NFLAG       = 10;
    localparam int B_RX_UNDER  = 0;
    localparam int B_RX_OVER   = 1;
    localparam int B_RX_FULL   = 2;
    localparam int B_TX_OVER   = 3;
    localparam int B_TX_EMPTY  = 4;
    localparam int B_TX_ABORT  = 5;
    localparam int B_ACTIVITY  = 6;
    localparam int B_STOP      = 7;
    localparam int B_START     = 8;
    localparam int B_GCALL     = 9;
    localparam int NERR        = 3;
    localparam int NEVT        = 5;
    typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/isu_level_flags.sv
module isu_level_flags #(
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             idle,
    input  logic             abort_hold,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] rx_thresh,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] tx_thresh,
    output logic             rx_full,
    output logic             tx_empty
);
    typedef struct packed {
        logic rx_full;
        logic tx_empty;
    } lvl_t;

    lvl_t lvl_d, lvl_q;

    always_comb begin
        lvl_d = lvl_q;
        if (en) begin
            lvl_d.rx_full  = (rx_level >= rx_thresh);
            lvl_d.tx_empty = abort_hold || (tx_level <= tx_thresh);
        end else begin
            lvl_d.rx_full  = 1'b0;
            lvl_d.tx_empty = !idle;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_d;
    end

    assign rx_full  = lvl_q.rx_full;
    assign tx_empty = lvl_q.tx_empty;

    AST_RXFULL_AT_TH: assert property (@(posedge clk) disable iff (!rst_n)
        (en && rx_level >= rx_thresh) |=> rx_full); // R2
    AST_TXEMPTY_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !abort_hold && tx_level > tx_thresh) |=> !tx_empty); // R3
    AST_RXFULL_DIS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !rx_full); // R5
    AST_TXEMPTY_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (en && abort_hold) |=> tx_empty); // R7
endmodule

// File: rtl/isu_err_flags.sv
module isu_err_flags #(
    parameter int DEPTH = 8,
    parameter int LVL_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    idle,
    input  logic                    abort_hold,
    input  logic [LVL_W-1:0]        rx_level,
    input  logic [LVL_W-1:0]        tx_level,
    input  logic                    rx_pop,
    input  logic                    rx_push,
    input  logic                    tx_push,
    input  logic [isu_pkg::NERR-1:0] clr,
    output logic [isu_pkg::NERR-1:0] err
);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
    localparam int NE = isu_pkg::NERR;

    typedef struct packed {
        logic [NE-1:0] err;
    } err_t;

    err_t err_d, err_q;
    logic [NE-1:0] set_v;
    logic          idle_clr;

    always_comb begin
        set_v[0] = en && rx_pop  && (rx_level == '0);
        set_v[1] = en && rx_push && (rx_level == FULL_LVL);
        set_v[2] = en && tx_push && !abort_hold && (tx_level == FULL_LVL);
        idle_clr = !en && idle;
        err_d    = err_q;
        for (int i = 0; i < NE; i++) begin
            err_d.err[i] = set_v[i] || (err_q.err[i] && !clr[i] && !idle_clr);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= err_d;
    end

    assign err = err_q.err;

    AST_UNDER_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (en && rx_pop && rx_level == '0) |=> err[0]); // R4
    AST_ERR_IDLE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && idle) |=> (err == '0)); // R6
    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !idle && clr == '0) |=> (err == $past(err))); // R6
endmodule

// File: rtl/isu_event_flags.sv
module isu_event_flags #(
    parameter int CAUSE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic [isu_pkg::NEVT-1:0] ev,
    input  logic [CAUSE_W-1:0]       cause_in,
    input  logic [isu_pkg::NEVT-1:0] clr,
    output logic [isu_pkg::NEVT-1:0] flg,
    output logic [CAUSE_W-1:0]       cause
);
    localparam int NV = isu_pkg::NEVT;
    localparam int GC = NV - 1;

    typedef struct packed {
        logic [NV-1:0]      flg;
        logic [CAUSE_W-1:0] cause;
    } evt_t;

    evt_t evt_d, evt_q;
    logic [NV-1:0] set_v;
    logic [NV-1:0] keep_v;

    always_comb begin
        set_v      = ev;
        set_v[GC]  = ev[GC] && en;
        keep_v     = ~clr;
        keep_v[GC] = !clr[GC] && en;
        evt_d      = evt_q;
        for (int i = 0; i < NV; i++) begin
            evt_d.flg[i] = set_v[i] || (evt_q.flg[i] && keep_v[i]);
        end
        if (clr[0]) evt_d.cause = '0;
        if (ev[0])  evt_d.cause = evt_d.cause | cause_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= evt_d;
    end

    assign flg   = evt_q.flg;
    assign cause = evt_q.cause;

    AST_ABORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (flg[0] && !clr[0]) |=> flg[0]); // R7
    AST_CAUSE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[0] && !ev[0]) |=> (cause == '0 && !flg[0])); // R7
    AST_GCALL_DIS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !flg[GC]); // R8
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (flg[1] && !clr[1]) |=> flg[1]); // R8
endmodule

// File: rtl/i2c_irq_status.sv
module i2c_irq_status #(
    parameter int DEPTH   = 8,
    parameter int CAUSE_W = 8,
    parameter int LVL_W   = $clog2(DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ctrl_en,
    input  logic                      fsm_idle,
    input  logic [LVL_W-1:0]          rx_level,
    input  logic [LVL_W-1:0]          rx_thresh,
    input  logic [LVL_W-1:0]          tx_level,
    input  logic [LVL_W-1:0]          tx_thresh,
    input  logic                      rx_pop,
    input  logic                      rx_push,
    input  logic                      tx_push,
    input  logic                      ev_abort,
    input  logic [CAUSE_W-1:0]        abort_cause,
    input  logic                      ev_activity,
    input  logic                      ev_stop,
    input  logic                      ev_start,
    input  logic                      ev_gcall,
    input  logic [isu_pkg::NFLAG-1:0] flag_clr,
    input  logic                      clr_all,
    input  logic [isu_pkg::NFLAG-1:0] irq_mask,
    output logic [isu_pkg::NFLAG-1:0] raw_status,
    output logic                      irq,
    output logic                      tx_flush,
    output logic [CAUSE_W-1:0]        abort_src
);
    import isu_pkg::*;

    logic [NFLAG-1:0] clr_eff;
    logic [NERR-1:0]  err_clr, err_v;
    logic [NEVT-1:0]  evt_in, evt_clr, evt_v;
    logic             rx_full, tx_empty, abort_hold;

    assign clr_eff    = flag_clr | {NFLAG{clr_all}};
    assign err_clr    = {clr_eff[B_TX_OVER], clr_eff[B_RX_OVER], clr_eff[B_RX_UNDER]};
    assign evt_clr    = {clr_eff[B_GCALL], clr_eff[B_START], clr_eff[B_STOP],
                         clr_eff[B_ACTIVITY], clr_eff[B_TX_ABORT]};
    assign evt_in     = {ev_gcall, ev_start, ev_stop, ev_activity, ev_abort};
    assign abort_hold = evt_v[0];

    isu_level_flags #(.LVL_W(LVL_W)) u_lvl (
        .clk(clk), .rst_n(rst_n), .en(ctrl_en), .idle(fsm_idle),
        .abort_hold(abort_hold),
        .rx_level(rx_level), .rx_thresh(rx_thresh),
        .tx_level(tx_level), .tx_thresh(tx_thresh),
        .rx_full(rx_full), .tx_empty(tx_empty)
    );

    isu_err_flags #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_err (
        .clk(clk), .rst_n(rst_n), .en(ctrl_en), .idle(fsm_idle),
        .abort_hold(abort_hold),
        .rx_level(rx_level), .tx_level(tx_level),
        .rx_pop(rx_pop), .rx_push(rx_push), .tx_push(tx_push),
        .clr(err_clr), .err(err_v)
    );

    isu_event_flags #(.CAUSE_W(CAUSE_W)) u_evt (
        .clk(clk), .rst_n(rst_n), .en(ctrl_en),
        .ev(evt_in), .cause_in(abort_cause), .clr(evt_clr),
        .flg(evt_v), .cause(abort_src)
    );

    always_comb begin
        raw_status             = '0;
        raw_status[B_RX_UNDER] = err_v[0];
        raw_status[B_RX_OVER]  = err_v[1];
        raw_status[B_TX_OVER]  = err_v[2];
        raw_status[B_RX_FULL]  = rx_full;
        raw_status[B_TX_EMPTY] = tx_empty;
        raw_status[B_TX_ABORT] = evt_v[0];
        raw_status[B_ACTIVITY] = evt_v[1];
        raw_status[B_STOP]     = evt_v[2];
        raw_status[B_START]    = evt_v[3];
        raw_status[B_GCALL]    = evt_v[4];
    end

    assign irq      = |(raw_status & irq_mask);
    assign tx_flush = abort_hold || !ctrl_en;

    AST_RXFULL_NO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_eff[B_RX_FULL] && ctrl_en && rx_level >= rx_thresh) |=> raw_status[B_RX_FULL]); // R9
    AST_TXEMPTY_NO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_eff[B_TX_EMPTY] && ctrl_en && tx_level <= tx_thresh) |=> raw_status[B_TX_EMPTY]); // R9
    AST_START_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start |=> raw_status[B_START]); // R8
    AST_FLUSH_ON_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        ev_abort |=> tx_flush); // R7
endmodule

// File: tb/i2c_irq_status_test.sv
module i2c_irq_status_test;
    localparam int DEPTH = 8;
    localparam int CW    = 8;
    localparam int LW    = 4;
    localparam int NF    = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en, idle, pop, rpush, tpush, e_abort, e_act, e_stop, e_start, e_gcall, clr_all;
    logic [LW-1:0] rl, rth, tl, tth;
    logic [CW-1:0] cause_in;
    logic [NF-1:0] clr, mask;
    logic [NF-1:0] raw;
    logic          irq, flush;
    logic [CW-1:0] src;

    logic [NF-1:0] exp_raw;
    logic [CW-1:0] exp_cause;
    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    i2c_irq_status #(.DEPTH(DEPTH), .CAUSE_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .ctrl_en(en), .fsm_idle(idle),
        .rx_level(rl), .rx_thresh(rth), .tx_level(tl), .tx_thresh(tth),
        .rx_pop(pop), .rx_push(rpush), .tx_push(tpush),
        .ev_abort(e_abort), .abort_cause(cause_in),
        .ev_activity(e_act), .ev_stop(e_stop), .ev_start(e_start), .ev_gcall(e_gcall),
        .flag_clr(clr), .clr_all(clr_all), .irq_mask(mask),
        .raw_status(raw), .irq(irq), .tx_flush(flush), .abort_src(src)
    );

    function automatic string bit_req(int i);
        case (i)
            0, 1, 3: return "R4";
            2:       return "R2";
            4:       return "R3";
            5:       return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(string req, string what, int got, int expv);
        n_chk++;
        if (got != expv) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, expv);
        end
    endtask

    task automatic quiet();
        pop = 0; rpush = 0; tpush = 0; e_abort = 0; e_act = 0; e_stop = 0;
        e_start = 0; e_gcall = 0; clr = '0; clr_all = 0; cause_in = '0;
    endtask

    task automatic compare_all(string ctx);
        for (int i = 0; i < NF; i++) begin
            if (raw[i] !== exp_raw[i])
                chk(bit_req(i), $sformatf("%s bit%0d", ctx, i), int'(raw[i]), int'(exp_raw[i]));
        end
        chk("R9", {ctx, " raw vector"}, int'(raw), int'(exp_raw));
        chk("R7", {ctx, " abort_src"}, int'(src), int'(exp_cause));
        chk("R7", {ctx, " tx_flush"}, int'(flush), int'(exp_raw[5] || !en));
        chk("R10", {ctx, " irq"}, int'(irq), int'(|(exp_raw & mask)));
    endtask

    // Advance one cycle: model next state from requirements, then compare.
    task automatic step(string ctx);
        logic [NF-1:0] n, cv;
        logic [CW-1:0] nc;
        logic ab, ic;
        cv = clr | {NF{clr_all}};
        ab = exp_raw[5];
        ic = !en && idle;
        n  = '0;
        n[2] = en && (rl >= rth);
        n[4] = en ? (ab || (tl <= tth)) : !idle;
        n[0] = (en && pop && rl == 0) || (exp_raw[0] && !cv[0] && !ic);
        n[1] = (en && rpush && rl == LW'(DEPTH)) || (exp_raw[1] && !cv[1] && !ic);
        n[3] = (en && tpush && !ab && tl == LW'(DEPTH)) || (exp_raw[3] && !cv[3] && !ic);
        n[5] = e_abort || (exp_raw[5] && !cv[5]);
        n[6] = e_act   || (exp_raw[6] && !cv[6]);
        n[7] = e_stop  || (exp_raw[7] && !cv[7]);
        n[8] = e_start || (exp_raw[8] && !cv[8]);
        n[9] = (en && e_gcall) || (exp_raw[9] && !cv[9] && en);
        nc = cv[5] ? '0 : exp_cause;
        if (e_abort) nc = nc | cause_in;
        @(negedge clk);
        exp_raw   = n;
        exp_cause = nc;
        compare_all(ctx);
    endtask

    initial begin
        #1500000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd24601));
        quiet();
        en = 0; idle = 1; rl = 0; rth = 4; tl = 0; tth = 0; mask = '0;
        exp_raw = '0; exp_cause = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state before the first active edge
        chk("R1", "raw after reset", int'(raw), 0);
        chk("R1", "abort_src after reset", int'(src), 0);
        chk("R1", "irq after reset", int'(irq), 0);

        // R2 receive threshold boundary
        en = 1; rth = 4; rl = 4; step("R2 at threshold");
        chk("R2", "rx_full at level==thresh", int'(raw[2]), 1);
        rl = 3; step("R2 below threshold");
        chk("R2", "rx_full below thresh", int'(raw[2]), 0);

        // R3 transmit threshold boundary
        tth = 2; tl = 2; step("R3 at threshold");
        chk("R3", "tx_empty at level==thresh", int'(raw[4]), 1);
        tl = 3; step("R3 above threshold");
        chk("R3", "tx_empty above thresh", int'(raw[4]), 0);

        // R4 underflow and overflows
        rl = 0; pop = 1; step("R4 rx underflow");
        chk("R4", "rx_under", int'(raw[0]), 1);
        quiet(); rl = 8; rpush = 1; step("R4 rx overflow");
        chk("R4", "rx_over", int'(raw[1]), 1);
        quiet(); tl = 8; tpush = 1; step("R4 tx overflow");
        chk("R4", "tx_over", int'(raw[3]), 1);
        quiet();

        // R5 and R6: disabled while busy, then idle
        en = 0; idle = 0; step("R6 disabled busy");
        chk("R6", "errors held while busy", int'({raw[3], raw[1], raw[0]}), 7);
        chk("R5", "rx_full while disabled", int'(raw[2]), 0);
        chk("R5", "tx_empty while disabled busy", int'(raw[4]), 1);
        idle = 1; step("R6 disabled idle");
        chk("R6", "errors cleared at idle", int'({raw[3], raw[1], raw[0]}), 0);
        chk("R5", "tx_empty disabled idle", int'(raw[4]), 0);

        // R7 abort hold and cause accumulation
        en = 1; tl = 8; tth = 0; e_abort = 1; cause_in = 8'h05; step("R7 abort");
        chk("R7", "abort bit", int'(raw[5]), 1);
        chk("R7", "flush", int'(flush), 1);
        cause_in = 8'h30; step("R7 second abort");
        chk("R7", "cause accumulate", int'(src), 8'h35);
        quiet(); tpush = 1; step("R7 held");
        chk("R7", "tx_empty forced while held", int'(raw[4]), 1);
        chk("R7", "no tx_over while flushed", int'(raw[3]), 0);
        quiet(); clr[5] = 1; step("R7 clear");
        chk("R7", "abort cleared", int'(raw[5]), 0);
        chk("R7", "cause cleared", int'(src), 0);
        quiet(); step("R7 level back");
        chk("R3", "tx_empty after abort clear", int'(raw[4]), 0);

        // R8 sticky events
        e_start = 1; step("R8 start"); quiet();
        step("R8 start hold");
        chk("R8", "start sticky", int'(raw[8]), 1);
        e_gcall = 1; step("R8 gcall"); quiet();
        chk("R8", "gcall set", int'(raw[9]), 1);
        en = 0; step("R8 gcall disable");
        chk("R8", "gcall cleared by disable", int'(raw[9]), 0);
        en = 1; e_gcall = 1; en = 0; step("R8 gcall ignored disabled");
        chk("R8", "gcall not set while disabled", int'(raw[9]), 0);
        quiet(); en = 1;

        // R9 selective clear, level ignore, set wins, clear all
        e_act = 1; e_stop = 1; step("R9 setup"); quiet();
        clr[7] = 1; step("R9 clear stop");
        chk("R9", "stop cleared", int'(raw[7]), 0);
        chk("R9", "activity kept", int'(raw[6]), 1);
        quiet(); rl = 6; rth = 2; clr[2] = 1; step("R9 level ignores clear");
        chk("R9", "rx_full ignores clear", int'(raw[2]), 1);
        quiet(); clr[6] = 1; e_act = 1; step("R9 set wins");
        chk("R9", "set beats clear", int'(raw[6]), 1);
        quiet(); e_abort = 1; cause_in = 8'h81; e_stop = 1; step("R9 reload"); quiet();
        clr_all = 1; step("R9 clear all");
        chk("R9", "latched bits after clear all", int'(raw & 10'b11_1110_1011), 0);
        chk("R9", "cause after clear all", int'(src), 0);
        quiet();

        // R10 masking
        e_act = 1; step("R10 setup"); quiet();
        mask = 10'b00_0100_0000; #1;
        chk("R10", "irq unmasked activity", int'(irq), 1);
        mask = 10'b00_1000_0000; #1;
        chk("R10", "irq masked activity", int'(irq), 0);

        // Random phase
        for (int k = 0; k < 4000; k++) begin
            logic [7:0] r;
            quiet();
            r = 8'($urandom);
            en    = ($urandom_range(9, 0) < 8);
            idle  = $urandom_range(1, 0) == 1;
            rl    = (r[1:0] == 0) ? LW'(0) : (r[1:0] == 1) ? LW'(DEPTH) : LW'($urandom_range(DEPTH, 0));
            tl    = (r[3:2] == 0) ? LW'(0) : (r[3:2] == 1) ? LW'(DEPTH) : LW'($urandom_range(DEPTH, 0));
            rth   = LW'($urandom_range(DEPTH, 0));
            tth   = LW'($urandom_range(DEPTH, 0));
            pop   = $urandom_range(3, 0) == 0;
            rpush = $urandom_range(3, 0) == 0;
            tpush = $urandom_range(3, 0) == 0;
            e_abort = $urandom_range(15, 0) == 0;
            cause_in = CW'($urandom);
            e_act   = $urandom_range(4, 0) == 0;
            e_stop  = $urandom_range(4, 0) == 0;
            e_start = $urandom_range(4, 0) == 0;
            e_gcall = $urandom_range(4, 0) == 0;
            if ($urandom_range(9, 0) == 0) clr = NF'($urandom);
            clr_all = $urandom_range(29, 0) == 0;
            mask    = NF'($urandom);
            step("random");
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule